// File: doc/BRIEF.md
# Drawing Command Packet Framer

This block sits between a 32-bit command word stream and a triangle/rectangle rasterizer. Each word arrives on a valid/ready input port. The framer reads the opcode in the top byte of the first word of each packet and looks up, in a fixed per-opcode table, how many parameter words follow. It collects the whole packet into a small local store. Only once the packet is complete does it emit the packet to the rasterizer, with start and end markers. A packet cut short by a soft clear therefore never reaches the rasterizer.

As each packet completes, the framer applies the packet's side effects to an eight-entry bank of drawing-state shadow registers. The state-register opcodes load a whole word into one register. Textured primitives refresh the texture-page field of register 1. A thirteen-bit status field is built from the bank. The framer also pulses a dirty flag for every opcode that draws into the frame buffer.

Two opcodes start an image transfer instead of a drawing packet. Their two parameter words go to a transfer engine as position and size. While that engine reports an image write in progress, words arriving at a packet boundary pass straight through to the engine.

Top module: `cmd_pkt_framer`

## Requirements
- R1: The opcode is bits [31:24] of a packet's first word, and the packet holds 1 + N words. N is 2 for 0x02. N is 3/6/4/8/5/8/7/11 for the eight groups of four opcodes 0x20..0x3F in ascending order. N is 2 for 0x40..0x47, 3 for 0x48..0x57 and 4 for 0x58..0x5F. N is 2/3/1/0/1/2/1/2 for the eight groups of four in 0x60..0x7F. N is 3 for 0x80, 2 for 0xA0 and 0xC0, and 0 for every other opcode.
- R2: A drawing packet is emitted on the rasterizer port only after all of its words have been accepted. Its words go out in arrival order on consecutive accepted cycles. rast_sop is high on the first word only and rast_eop on the last word only. in_ready is low while a packet is being emitted.
- R3: While rast_valid is high and rast_ready is low, rast_data, rast_sop and rast_eop hold their values and no input word is accepted.
- R4: After reset, shadow register i holds (0xE0+i) shifted left by 24. Register i is visible on shadow_flat[32i+31:32i]. A completed packet with opcode 0xE0..0xE7 loads its whole first word into register (opcode & 7).
- R5: When (opcode & 0xF4) == 0x24, bits [8:0] of packet word 4 replace bits [8:0] of shadow register 1. When (opcode & 0xF4) == 0x34, packet word 5 is used instead. All other bits are kept.
- R6: status_low[10:0] equals shadow register 1 bits [10:0], and status_low[12:11] equals shadow register 6 bits [1:0].
- R7: fb_dirty_pulse is high for exactly one cycle for each completed packet whose opcode lies in 0x02..0xBF, and is never high for any other packet.
- R8: Opcodes 0xA0 and 0xC0 are never emitted to the rasterizer. When the packet completes, xfer_start pulses for one cycle, with xfer_pos = word 1 and xfer_size = word 2. xfer_is_read is 1 for 0xC0 and 0 for 0xA0.
- R9: While xfer_wr_active is high at a packet boundary, each input word is presented on xfer_data/xfer_valid, and in_ready follows xfer_ready. Nothing reaches the rasterizer port.
- R10: A soft_clr pulse discards a partly collected packet, and in_ready is low while soft_clr is high. The next word accepted is treated as a new opcode word.
- R11: After reset, in_ready is 1, rast_valid and xfer_valid are 0, and status_low is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| soft_clr | input | 1 | Drops a partly collected packet |
| in_data | input | 32 | Command word |
| in_valid | input | 1 | Command word valid |
| in_ready | output | 1 | Command word accepted when high with in_valid |
| rast_data | output | 32 | Packet word to rasterizer |
| rast_valid | output | 1 | Packet word valid |
| rast_sop | output | 1 | First word of packet |
| rast_eop | output | 1 | Last word of packet |
| rast_ready | input | 1 | Rasterizer accepts word |
| xfer_wr_active | input | 1 | Transfer engine is consuming image-write data |
| xfer_data | output | 32 | Image-write word to transfer engine |
| xfer_valid | output | 1 | Image-write word valid |
| xfer_ready | input | 1 | Transfer engine accepts word |
| xfer_start | output | 1 | One-cycle transfer start pulse |
| xfer_is_read | output | 1 | Started transfer is a read |
| xfer_pos | output | 32 | Transfer position word |
| xfer_size | output | 32 | Transfer size word |
| shadow_flat | output | 256 | Eight shadow registers, register i at [32i+31:32i] |
| status_low | output | 13 | Status bits rebuilt from shadow registers |
| fb_dirty_pulse | output | 1 | Frame buffer dirty pulse |

## Verification
The bench builds the framer with its default parameters: 32-bit words, a twelve-word packet store and eight shadow registers. With a twelve-word store, the longest packet in the table (opcode group 0x3C, twelve words) fills every entry. The vector walk therefore reaches the store's last index and the end-marker compare at its widest value. With eight registers, every state-register opcode from 0xE0 to 0xE7 has its own slot, including slots 1 and 6 that feed the status field.

// File: rtl/fw_pkg.sv
// fw_pkg: shared constants, types and the opcode length table of the
// command packet framer. Assumes 8-bit opcodes in the top byte of a word.
package fw_pkg;

    localparam int OP_W       = 8;
    localparam int TBL_W      = 4;
    localparam int TEX_BITS   = 9;
    localparam int STATUS_W   = 13;
    localparam int TEX_SLOT   = 1;
    localparam int MODE_SLOT  = 6;
    localparam int TEX_WORD_A = 4;
    localparam int TEX_WORD_B = 5;

    typedef enum logic [0:0] {
        ST_GATHER = 1'b0,
        ST_SEND   = 1'b1
    } fr_state_t;

    // Number of parameter words that follow the opcode word.
    function automatic logic [TBL_W-1:0] param_words(input logic [OP_W-1:0] op);
        logic [TBL_W-1:0] n;
        n = '0;
        if (op == 8'h02) begin
            n = 4'd2;
        end else if (op >= 8'h20 && op <= 8'h3F) begin
            case (op[4:2])
                3'd0: n = 4'd3;
                3'd1: n = 4'd6;
                3'd2: n = 4'd4;
                3'd3: n = 4'd8;
                3'd4: n = 4'd5;
                3'd5: n = 4'd8;
                3'd6: n = 4'd7;
                default: n = 4'd11;
            endcase
        end else if (op >= 8'h40 && op <= 8'h5F) begin
            if (op < 8'h48)      n = 4'd2;
            else if (op < 8'h58) n = 4'd3;
            else                 n = 4'd4;
        end else if (op >= 8'h60 && op <= 8'h7F) begin
            case (op[4:2])
                3'd0: n = 4'd2;
                3'd1: n = 4'd3;
                3'd2: n = 4'd1;
                3'd3: n = 4'd0;
                3'd4: n = 4'd1;
                3'd5: n = 4'd2;
                3'd6: n = 4'd1;
                default: n = 4'd2;
            endcase
        end else if (op == 8'h80) begin
            n = 4'd3;
        end else if (op == 8'hA0 || op == 8'hC0) begin
            n = 4'd2;
        end
        return n;
    endfunction

endpackage

// File: rtl/fw_len_decode.sv
// fw_len_decode: purely combinational opcode classifier. Gives the total
// packet length and the side-effect class of an opcode.
// Assumes CNT_W is wide enough to hold the longest packet (12 words).
module fw_len_decode
    import fw_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic [OP_W-1:0]  op,
    output logic [CNT_W-1:0] pkt_len,
    output logic             is_xfer,
    output logic             is_read,
    output logic             marks_dirty,
    output logic             is_state_op,
    output logic             tex_hit,
    output logic [CNT_W-1:0] tex_idx
);

    // Classify the opcode and compute the packet length.
    always_comb begin
        pkt_len     = CNT_W'(param_words(op)) + CNT_W'(1);
        is_xfer     = (op == 8'hA0) || (op == 8'hC0);
        is_read     = (op == 8'hC0);
        marks_dirty = (op >= 8'h02) && (op < 8'hC0);
        is_state_op = (op[7:3] == 5'b11100);
        tex_hit     = ((op & 8'hF4) == 8'h24) || ((op & 8'hF4) == 8'h34);
        tex_idx     = ((op & 8'hF4) == 8'h34) ? CNT_W'(TEX_WORD_B) : CNT_W'(TEX_WORD_A);
    end

endmodule

// File: rtl/fw_pkt_store.sv
// fw_pkt_store: word store for one packet with one write port and two
// asynchronous read ports (emission and side-effect snoop).
// Assumes indices stay below DEPTH.
module fw_pkt_store #(
    parameter int DEPTH = 12,
    parameter int W     = 32,
    parameter int IW    = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic [W-1:0]  wr_data,
    input  logic [IW-1:0] rd_a_idx,
    output logic [W-1:0]  rd_a_data,
    input  logic [IW-1:0] rd_b_idx,
    output logic [W-1:0]  rd_b_data
);

    logic [W-1:0] mem [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_entry
        // Hold one packet word; written when its index is addressed.
        always_ff @(posedge clk) begin
            if (!rst_n)
                mem[i] <= '0;
            else if (wr_en && wr_idx == IW'(i))
                mem[i] <= wr_data;
        end
    end

    // Two independent read ports, zero when out of range.
    always_comb begin
        rd_a_data = '0;
        rd_b_data = '0;
        for (int k = 0; k < DEPTH; k++) begin
            if (rd_a_idx == IW'(k)) rd_a_data = mem[k];
            if (rd_b_idx == IW'(k)) rd_b_data = mem[k];
        end
    end

endmodule

// File: rtl/fw_shadow.sv
// fw_shadow: bank of drawing-state shadow registers plus the status field
// derived from them. Assumes N > MODE_SLOT and W >= 32.
module fw_shadow
    import fw_pkg::*;
#(
    parameter int N  = 8,
    parameter int W  = 32,
    parameter int SW = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [SW-1:0]       wr_sel,
    input  logic [W-1:0]        wr_word,
    input  logic                tex_en,
    input  logic [W-1:0]        tex_word,
    output logic [N*W-1:0]      shadow_flat,
    output logic [STATUS_W-1:0] status_low
);

    logic [W-1:0] regs [N];

    for (genvar i = 0; i < N; i++) begin : g_reg
        // Shadow register i: whole-word load, or texture-field merge in slot 1.
        always_ff @(posedge clk) begin
            if (!rst_n)
                regs[i] <= W'((32'hE0 + i) << 24);
            else if (wr_en && wr_sel == SW'(i))
                regs[i] <= wr_word;
            else if (i == TEX_SLOT && tex_en)
                regs[i] <= {regs[i][W-1:TEX_BITS], tex_word[TEX_BITS-1:0]};
        end
        assign shadow_flat[i*W +: W] = regs[i];
    end

    // Status field: mode bits of slot 6 above the low bits of slot 1.
    assign status_low = {regs[MODE_SLOT][1:0], regs[TEX_SLOT][10:0]};

endmodule

// File: rtl/cmd_pkt_framer.sv
// cmd_pkt_framer: frames a command word stream into packets by opcode,
// emits complete packets to a rasterizer, snoops side effects into the
// shadow bank and hands image transfers to a transfer engine.
// Assumes the transfer engine drops xfer_wr_active only at word boundaries.
module cmd_pkt_framer
    import fw_pkg::*;
#(
    parameter int WORD_W   = 32,
    parameter int MAX_PKT  = 12,
    parameter int SHADOW_N = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   soft_clr,
    input  logic [WORD_W-1:0]      in_data,
    input  logic                   in_valid,
    output logic                   in_ready,
    output logic [WORD_W-1:0]      rast_data,
    output logic                   rast_valid,
    output logic                   rast_sop,
    output logic                   rast_eop,
    input  logic                   rast_ready,
    input  logic                   xfer_wr_active,
    output logic [WORD_W-1:0]      xfer_data,
    output logic                   xfer_valid,
    input  logic                   xfer_ready,
    output logic                   xfer_start,
    output logic                   xfer_is_read,
    output logic [WORD_W-1:0]      xfer_pos,
    output logic [WORD_W-1:0]      xfer_size,
    output logic [SHADOW_N*WORD_W-1:0] shadow_flat,
    output logic [STATUS_W-1:0]    status_low,
    output logic                   fb_dirty_pulse
);

    localparam int CNT_W = $clog2(MAX_PKT + 1);
    localparam int SEL_W = $clog2(SHADOW_N);

    fr_state_t        state_q;
    logic [CNT_W-1:0] fill_cnt;
    logic [CNT_W-1:0] send_idx;
    logic [CNT_W-1:0] len_q;
    logic [OP_W-1:0]  op_q;

    logic [OP_W-1:0]  cur_op;
    logic [CNT_W-1:0] cur_len;
    logic             d_xfer, d_read, d_dirty, d_state, d_tex;
    logic [CNT_W-1:0] d_tex_idx;
    logic             at_boundary, route_xfer, accept, last_word;
    logic [WORD_W-1:0] snoop_word;

    // Opcode under decode: the live word at a boundary, else the held one.
    assign cur_op = (fill_cnt == '0) ? in_data[WORD_W-1 -: OP_W] : op_q;

    fw_len_decode #(.CNT_W(CNT_W)) u_dec (
        .op          (cur_op),
        .pkt_len     (cur_len),
        .is_xfer     (d_xfer),
        .is_read     (d_read),
        .marks_dirty (d_dirty),
        .is_state_op (d_state),
        .tex_hit     (d_tex),
        .tex_idx     (d_tex_idx)
    );

    // Handshake steering: boundary routing, emission blocking, soft clear.
    always_comb begin
        at_boundary = (state_q == ST_GATHER) && (fill_cnt == '0);
        route_xfer  = at_boundary && xfer_wr_active;
        if (soft_clr || state_q == ST_SEND)
            in_ready = 1'b0;
        else if (route_xfer)
            in_ready = xfer_ready;
        else
            in_ready = 1'b1;
        accept     = in_valid && in_ready && !route_xfer;
        last_word  = accept && (fill_cnt == cur_len - CNT_W'(1));
        xfer_valid = route_xfer && in_valid && !soft_clr;
        xfer_data  = in_data;
    end

    fw_pkt_store #(.DEPTH(MAX_PKT), .W(WORD_W), .IW(CNT_W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (accept),
        .wr_idx    (fill_cnt),
        .wr_data   (in_data),
        .rd_a_idx  (send_idx),
        .rd_a_data (rast_data),
        .rd_b_idx  (d_tex_idx),
        .rd_b_data (snoop_word)
    );

    fw_shadow #(.N(SHADOW_N), .W(WORD_W), .SW(SEL_W)) u_shadow (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (last_word && d_state),
        .wr_sel      (cur_op[SEL_W-1:0]),
        .wr_word     (in_data),
        .tex_en      (last_word && d_tex),
        .tex_word    (snoop_word),
        .shadow_flat (shadow_flat),
        .status_low  (status_low)
    );

    // Collection counter and held opcode; soft clear drops partial packets.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fill_cnt <= '0;
            op_q     <= '0;
        end else if (soft_clr && state_q == ST_GATHER) begin
            fill_cnt <= '0;
        end else if (last_word) begin
            fill_cnt <= '0;
        end else if (accept) begin
            fill_cnt <= fill_cnt + CNT_W'(1);
            if (fill_cnt == '0) op_q <= in_data[WORD_W-1 -: OP_W];
        end
    end

    // Packet completion: start emission or launch a transfer, pulse dirty.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q        <= ST_GATHER;
            send_idx       <= '0;
            len_q          <= '0;
            xfer_start     <= 1'b0;
            xfer_is_read   <= 1'b0;
            xfer_pos       <= '0;
            xfer_size      <= '0;
            fb_dirty_pulse <= 1'b0;
        end else begin
            xfer_start     <= 1'b0;
            fb_dirty_pulse <= last_word && d_dirty;
            if (accept && fill_cnt == CNT_W'(1))
                xfer_pos <= in_data;
            if (state_q == ST_GATHER) begin
                if (last_word && d_xfer) begin
                    xfer_start   <= 1'b1;
                    xfer_is_read <= d_read;
                    xfer_size    <= in_data;
                end else if (last_word) begin
                    state_q  <= ST_SEND;
                    send_idx <= '0;
                    len_q    <= cur_len;
                end
            end else if (rast_ready) begin
                if (rast_eop) state_q <= ST_GATHER;
                else          send_idx <= send_idx + CNT_W'(1);
            end
        end
    end

    // Emission markers from the emit index.
    always_comb begin
        rast_valid = (state_q == ST_SEND);
        rast_sop   = rast_valid && (send_idx == '0);
        rast_eop   = rast_valid && (send_idx == len_q - CNT_W'(1));
    end

endmodule

// File: rtl/fw_checker.sv
// fw_checker: port-level temporal properties of the framer, bound to it.
module fw_checker #(
    parameter int WORD_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              soft_clr,
    input logic              in_ready,
    input logic [WORD_W-1:0] rast_data,
    input logic              rast_valid,
    input logic              rast_sop,
    input logic              rast_eop,
    input logic              rast_ready,
    input logic              xfer_valid,
    input logic              xfer_start
);

    AST_SEND_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        rast_valid |-> !in_ready); // R2
    AST_EOP_ENDS_PACKET: assert property (@(posedge clk) disable iff (!rst_n)
        (rast_valid && rast_ready && rast_eop) |=> !rast_valid); // R2
    AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (rast_valid && !rast_ready) |=> (rast_valid && $stable(rast_data) && $stable(rast_sop) && $stable(rast_eop))); // R3
    AST_CLEAR_STOPS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        soft_clr |-> !in_ready); // R10
    AST_START_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_start |-> !rast_valid); // R8
    AST_START_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_start |=> !xfer_start); // R8
    AST_ROUTE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_valid |-> !rast_valid); // R9

endmodule

bind cmd_pkt_framer fw_checker #(.WORD_W(WORD_W)) u_fw_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .soft_clr   (soft_clr),
    .in_ready   (in_ready),
    .rast_data  (rast_data),
    .rast_valid (rast_valid),
    .rast_sop   (rast_sop),
    .rast_eop   (rast_eop),
    .rast_ready (rast_ready),
    .xfer_valid (xfer_valid),
    .xfer_start (xfer_start)
);

// File: tb/tb_cmd_pkt_framer.sv
module tb_cmd_pkt_framer;

    localparam int CLK_PERIOD = 10;
    localparam int NV = 19;
    // Vector: opcode[11:4], expected packet length[3:0]
    localparam logic [11:0] VEC [NV] = '{
        {8'h00, 4'd1},  {8'h02, 4'd3},  {8'h20, 4'd4},  {8'h24, 4'd7},
        {8'h28, 4'd5},  {8'h2C, 4'd9},  {8'h30, 4'd6},  {8'h34, 4'd9},
        {8'h38, 4'd8},  {8'h3C, 4'd12}, {8'h44, 4'd3},  {8'h4C, 4'd4},
        {8'h5A, 4'd5},  {8'h6D, 4'd1},  {8'h66, 4'd4},  {8'h7E, 4'd3},
        {8'h80, 4'd4},  {8'hE5, 4'd1},  {8'hFF, 4'd1}
    };

    logic clk = 1'b0, rst_n = 1'b0, soft_clr = 1'b0;
    logic [31:0] in_data = '0;
    logic in_valid = 1'b0, rast_ready = 1'b1;
    logic xfer_wr_active = 1'b0, xfer_ready = 1'b0;
    logic in_ready, rast_valid, rast_sop, rast_eop, xfer_valid, xfer_start, xfer_is_read, fb_dirty_pulse;
    logic [31:0] rast_data, xfer_data, xfer_pos, xfer_size;
    logic [255:0] shadow_flat;
    logic [12:0] status_low;

    int n_checks = 0, n_fail = 0;
    int cap_n = 0, eop_n = 0, dirty_n = 0, start_n = 0, xw_n = 0;
    logic [31:0] cap_d [16];
    logic cap_sop [16];
    logic cap_eop [16];
    logic [31:0] xw_last, st_pos, st_size;
    logic st_rd;

    always #(CLK_PERIOD/2) clk = ~clk;

    cmd_pkt_framer dut (
        .clk(clk), .rst_n(rst_n), .soft_clr(soft_clr),
        .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
        .rast_data(rast_data), .rast_valid(rast_valid), .rast_sop(rast_sop),
        .rast_eop(rast_eop), .rast_ready(rast_ready),
        .xfer_wr_active(xfer_wr_active), .xfer_data(xfer_data), .xfer_valid(xfer_valid),
        .xfer_ready(xfer_ready), .xfer_start(xfer_start), .xfer_is_read(xfer_is_read),
        .xfer_pos(xfer_pos), .xfer_size(xfer_size), .shadow_flat(shadow_flat),
        .status_low(status_low), .fb_dirty_pulse(fb_dirty_pulse)
    );

    // Monitor: record handshakes at the falling edge, away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (rast_valid && rast_ready) begin
                if (cap_n < 16) begin
                    cap_d[cap_n] = rast_data; cap_sop[cap_n] = rast_sop; cap_eop[cap_n] = rast_eop;
                end
                cap_n++;
                if (rast_eop) eop_n++;
            end
            if (fb_dirty_pulse) dirty_n++;
            if (xfer_start) begin
                start_n++; st_pos = xfer_pos; st_size = xfer_size; st_rd = xfer_is_read;
            end
            if (xfer_valid && xfer_ready) begin
                xw_n++; xw_last = xfer_data;
            end
        end
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic send(input logic [31:0] w);
        @(posedge clk); #1;
        in_valid = 1'b1; in_data = w;
        do @(negedge clk); while (!in_ready);
        @(posedge clk); #1;
        in_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++; n_checks++;
        $display("FAIL watchdog expired actual=%h expected=%h", 32'h1, 32'h0);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        int d0;
        repeat (3) @(posedge clk); #1;
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        check(in_ready == 1'b1, "R11 in_ready", 32'(in_ready), 32'h1);
        check(!rast_valid && !xfer_valid, "R11 outputs idle", 32'({rast_valid, xfer_valid}), 32'h0);
        check(status_low == 13'h0, "R11 status", 32'(status_low), 32'h0);
        check(shadow_flat[3*32 +: 32] == 32'hE300_0000, "R4 reset slot3", shadow_flat[3*32 +: 32], 32'hE300_0000);

        // R1 R2 R7 vector walk over opcode length table
        for (int v = 0; v < NV; v++) begin
            logic [7:0] op;
            int len;
            bit dirty;
            op = VEC[v][11:4]; len = int'(VEC[v][3:0]);
            dirty = (op >= 8'h02) && (op < 8'hC0);
            cap_n = 0; eop_n = 0; d0 = dirty_n;
            for (int k = 0; k < len; k++)
                send((k == 0) ? {op, 24'h123456} : (32'h5A00_0000 | 32'(k)));
            idle(len + 4);
            check(cap_n == len, $sformatf("R1 length op %h", op), 32'(cap_n), 32'(len));
            check(cap_d[0] == {op, 24'h123456} && cap_sop[0] && cap_eop[len-1] && eop_n == 1,
                  $sformatf("R2 framing op %h", op), cap_d[0], {op, 24'h123456});
            if (len > 1)
                check(cap_d[len-1] == (32'h5A00_0000 | 32'(len-1)) && !cap_sop[len-1],
                      $sformatf("R2 last word op %h", op), cap_d[len-1], 32'h5A00_0000 | 32'(len-1));
            check((dirty_n - d0) == int'(dirty), $sformatf("R7 dirty op %h", op), 32'(dirty_n - d0), 32'(dirty));
        end
        // R5: last textured vector was 0x3C with word 5 = 0x5A000005
        check(shadow_flat[1*32 +: 32] == 32'hE100_0005, "R5 tex from vectors", shadow_flat[32 +: 32], 32'hE100_0005);
        check(shadow_flat[5*32 +: 32] == 32'hE512_3456, "R4 slot5 load", shadow_flat[5*32 +: 32], 32'hE512_3456);

        // R4 R6 state opcodes
        send(32'hE100_07FF); send(32'hE600_0002); idle(4);
        check(status_low == 13'h17FF, "R6 status build", 32'(status_low), 32'h17FF);
        // R5 textured word 4 (0x26)
        send(32'h2600_0000);
        for (int k = 1; k < 7; k++) send(k == 4 ? 32'h0000_00AB : 32'hFFFF_FE00);
        idle(10);
        check(shadow_flat[32 +: 32] == 32'hE100_06AB, "R5 word4 merge", shadow_flat[32 +: 32], 32'hE100_06AB);
        check(status_low == 13'h16AB, "R6 status after tex", 32'(status_low), 32'h16AB);
        // R5 textured word 5 (0x36), word 4 ignored
        send(32'h3600_0000);
        for (int k = 1; k < 9; k++) send(k == 5 ? 32'h0000_0133 : (k == 4 ? 32'h0000_01FF : 32'h0));
        idle(12);
        check(shadow_flat[32 +: 32] == 32'hE100_0733, "R5 word5 merge", shadow_flat[32 +: 32], 32'hE100_0733);

        // R3 stall
        @(posedge clk); #1 rast_ready = 1'b0;
        cap_n = 0;
        send(32'h4011_2233); send(32'h1); send(32'h2);
        idle(4);
        check(rast_valid && rast_sop && rast_data == 32'h4011_2233, "R3 held word", rast_data, 32'h4011_2233);
        check(!in_ready && cap_n == 0, "R3 input blocked", 32'({in_ready, 8'(cap_n)}), 32'h0);
        @(posedge clk); #1 rast_ready = 1'b1;
        idle(6);
        check(cap_n == 3 && cap_eop[2], "R3 release", 32'(cap_n), 32'd3);

        // R10 soft clear drops partial packet
        cap_n = 0;
        send(32'h2800_0000); send(32'h0000_0001);
        @(posedge clk); #1 soft_clr = 1'b1;
        @(negedge clk);
        check(!in_ready, "R10 ready low in clear", 32'(in_ready), 32'h0);
        @(posedge clk); #1 soft_clr = 1'b0;
        send(32'h00AB_CDEF); idle(5);
        check(cap_n == 1 && cap_d[0] == 32'h00AB_CDEF && cap_sop[0] && cap_eop[0],
              "R10 new packet after clear", cap_d[0], 32'h00AB_CDEF);

        // R8 image write start
        cap_n = 0; d0 = dirty_n;
        send(32'hA000_0000); send(32'h0010_0020); send(32'h0004_0008); idle(4);
        check(start_n == 1 && st_pos == 32'h0010_0020 && st_size == 32'h0004_0008 && !st_rd,
              "R8 write start", st_size, 32'h0004_0008);
        check(cap_n == 0 && dirty_n - d0 == 1, "R8 not emitted, dirty", 32'(cap_n), 32'h0);
        // R9 routing to transfer engine
        @(posedge clk); #1 xfer_wr_active = 1'b1; xfer_ready = 1'b1;
        for (int k = 0; k < 3; k++) send(32'h1111_0000 + 32'(k));
        idle(3);
        check(xw_n == 3 && xw_last == 32'h1111_0002 && cap_n == 0, "R9 routed words", xw_last, 32'h1111_0002);
        @(posedge clk); #1 xfer_ready = 1'b0; in_valid = 1'b1; in_data = 32'h2222_2222;
        @(negedge clk);
        check(!in_ready && !rast_valid, "R9 ready follows engine", 32'(in_ready), 32'h0);
        @(posedge clk); #1 in_valid = 1'b0; xfer_wr_active = 1'b0;
        // R8 image read start
        d0 = dirty_n;
        send(32'hC000_0000); send(32'h0003_0004); send(32'h0001_0002); idle(4);
        check(start_n == 2 && st_rd && st_pos == 32'h0003_0004 && st_size == 32'h0001_0002,
              "R8 read start", st_pos, 32'h0003_0004);
        check(dirty_n == d0 && cap_n == 0, "R7 read not dirty", 32'(dirty_n - d0), 32'h0);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule